// File: doc/BRIEF.md
# Operand Effective-Address Generator

This block turns an operand request from the decode stage of a 16/20-bit processor into the memory address that the operand access uses. It handles four operand modes: register indirect, indexed with a signed displacement, auto-incrementing register indirect, and absolute. For the auto-increment mode it also produces the new base-register value that the register file must take. The memory port and the register file are outside the block.

Each request is a single cycle with `req_valid` high. The address and write-back value are computed combinationally and captured in an output register. They appear with `rsp_valid` one cycle later. Extended instructions use a 20-bit signed displacement. Legacy instructions keep 16-bit address behaviour whenever their base lies in the low 64K.

Top module: `opnd_addr_gen`

## Requirements
- R1: `rsp_valid` is high in the cycle after each cycle with `req_valid` high, and low otherwise. `ea`, `wb_en` and `wb_value` are valid whenever `rsp_valid` is high.
- R2: Register-indirect mode (`mode` = 2'b00) gives `ea` = base. `disp` has no effect on the result.
- R3: Indexed mode (`mode` = 2'b01) gives `ea` = base + displacement, modulo 2^20. The displacement is signed. Its sign is taken from bit 15 of `disp` when `ext` = 0, and from bit 19 when `ext` = 1.
- R4: When `ext` = 0, `mode` is not absolute and base < 0x10000, `ea` is reduced to its low 16 bits. With base >= 0x10000 the full 20-bit sum is kept.
- R5: Absolute mode (`mode` = 2'b11) gives `ea` = `disp[19:0]` when `ext` = 1, and `ea` = `disp[15:0]` zero-extended when `ext` = 0. `base` has no effect.
- R6: Auto-increment mode (`mode` = 2'b10) gives `ea` = base and `wb_en` = 1. In every other mode `wb_en` = 0.
- R7: In auto-increment mode, `wb_value` = base + N, masked to 20 bits. N is 1 for `size` = 2'b00 (byte), 2 for 2'b01 (word), and 4 for 2'b10 or 2'b11 (wide).
- R8: When `is_sp` = 1 and base + N is odd, `wb_value` is base + N + 1, masked to 20 bits. When `is_sp` = 0, odd values are kept.
- R9: After synchronous reset, `rsp_valid`, `wb_en`, `ea` and `wb_value` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per operand |
| mode | input | 2 | 00 reg-indirect, 01 indexed, 10 auto-increment, 11 absolute |
| size | input | 2 | 00 byte, 01 word, 1x wide |
| ext | input | 1 | Extended-instruction flag |
| is_sp | input | 1 | Base register is the stack pointer |
| base | input | 20 | Base register value |
| disp | input | 20 | Displacement or absolute address |
| rsp_valid | output | 1 | Result valid |
| ea | output | 20 | Effective address |
| wb_en | output | 1 | Base register write-back enable |
| wb_value | output | 20 | New base register value |

## Verification
Every result is due exactly one clock edge after its request. The driver applies a request at a falling edge and pushes the expected item onto a queue. The monitor samples 2 ns after each rising edge. It pops one item for every cycle in which `rsp_valid` is high, and flags a response that arrives with nothing queued. Idle gaps between requests show whether `rsp_valid` drops after its single cycle. At the end, the bench also requires the queue to be empty, so that a missing response is reported too.

// File: rtl/oag_pkg.sv
package oag_pkg;
  typedef enum logic [1:0] {
    AM_REG  = 2'b00,
    AM_IDX  = 2'b01,
    AM_POST = 2'b10,
    AM_ABS  = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_WIDE = 2'b10,
    SZ_WID2 = 2'b11
  } osize_e;

  function automatic logic [2:0] step_bytes(input logic [1:0] sz);
    case (sz)
      2'b00:   step_bytes = 3'd1;
      2'b01:   step_bytes = 3'd2;
      default: step_bytes = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/oag_ea_calc.sv
module oag_ea_calc #(
  parameter int AW = 20,
  parameter int LW = 16
) (
  input  logic [1:0]    mode,
  input  logic          ext,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] disp,
  output logic [AW-1:0] ea
);
  import oag_pkg::*;
  localparam int HW = AW - LW;

  logic [AW-1:0] sdisp;
  logic [AW-1:0] addend;
  logic [AW-1:0] sum;
  logic          low_base;

  always_comb begin
    if (ext) sdisp = disp;
    else     sdisp = {{HW{disp[LW-1]}}, disp[LW-1:0]};
  end

  assign low_base = (base[AW-1:LW] == '0);

  always_comb begin
    addend = '0;
    if (mode == AM_IDX) addend = sdisp;
    sum = base + addend;
    if (mode == AM_ABS) begin
      if (ext) ea = disp;
      else     ea = {{HW{1'b0}}, disp[LW-1:0]};
    end else if (!ext && low_base) begin
      ea = {{HW{1'b0}}, sum[LW-1:0]};
    end else begin
      ea = sum;
    end
  end
endmodule

// File: rtl/oag_postinc.sv
module oag_postinc #(
  parameter int AW = 20
) (
  input  logic [1:0]    size,
  input  logic          is_sp,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] next_val
);
  import oag_pkg::*;

  logic [AW-1:0] bumped;

  always_comb begin
    bumped = base + AW'(step_bytes(size));
    if (is_sp && bumped[0]) next_val = bumped + AW'(1);
    else                    next_val = bumped;
  end
endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen #(
  parameter int AW = 20,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  input  logic          ext,
  input  logic          is_sp,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] disp,
  output logic          rsp_valid,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_value
);
  import oag_pkg::*;
  localparam logic [AW-1:0] LOW_LIMIT = AW'(1) << LW;

  logic [AW-1:0] ea_c;
  logic [AW-1:0] wb_c;

  oag_ea_calc #(.AW(AW), .LW(LW)) u_ea (
    .mode(mode), .ext(ext), .base(base), .disp(disp), .ea(ea_c)
  );

  oag_postinc #(.AW(AW)) u_inc (
    .size(size), .is_sp(is_sp), .base(base), .next_val(wb_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      wb_en     <= 1'b0;
      ea        <= '0;
      wb_value  <= '0;
    end else begin
      rsp_valid <= req_valid;
      wb_en     <= req_valid && (mode == AM_POST);
      if (req_valid) begin
        ea       <= ea_c;
        wb_value <= (mode == AM_POST) ? wb_c : '0;
      end
    end
  end

  // R1: one response per request, one cycle later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R6: write-back enable only alongside a response
  a_r6_wb_with_rsp: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> rsp_valid);
  // R6: auto-increment addresses at the unmodified base
  a_r6_post_ea: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == AM_POST) |=> (ea == $past(base)));
  // R8: stack pointer write-back always even
  a_r8_sp_even: assert property (@(posedge clk) disable iff (rst)
    (req_valid && mode == AM_POST && is_sp) |=> !wb_value[0]);
  // R4: legacy access below 64K stays below 64K
  a_r4_legacy_wrap: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ext && mode != AM_ABS && base < LOW_LIMIT) |=> (ea < LOW_LIMIT));
  // R5: legacy absolute address fits 16 bits
  a_r5_abs_legacy: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ext && mode == AM_ABS) |=> (ea < LOW_LIMIT));
endmodule

// File: tb/opnd_addr_gen_tb.sv
module opnd_addr_gen_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [1:0]    size = 2'b00;
  logic          ext = 1'b0;
  logic          is_sp = 1'b0;
  logic [AW-1:0] base = '0;
  logic [AW-1:0] disp = '0;
  logic          rsp_valid;
  logic [AW-1:0] ea;
  logic          wb_en;
  logic [AW-1:0] wb_value;

  always #4 clk = ~clk;

  opnd_addr_gen u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .mode(mode), .size(size),
    .ext(ext), .is_sp(is_sp), .base(base), .disp(disp),
    .rsp_valid(rsp_valid), .ea(ea), .wb_en(wb_en), .wb_value(wb_value)
  );

  typedef struct {
    logic [AW-1:0] ea;
    logic          wb_en;
    logic [AW-1:0] wb;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [1:0] m, input logic [1:0] sz, input logic x,
                                 input logic sp, input logic [AW-1:0] b, input logic [AW-1:0] d,
                                 input string tag);
    exp_t e;
    logic [AW-1:0] sd, s, w;
    int inc;
    sd = x ? d : {{4{d[15]}}, d[15:0]};
    case (m)
      2'b00: s = b;
      2'b01: s = b + sd;
      2'b10: s = b;
      default: s = x ? d : {4'h0, d[15:0]};
    endcase
    if (!x && m != 2'b11 && b < 20'h10000) s = s & 20'h0FFFF;
    inc = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    w = b + AW'(inc);
    if (sp && w[0]) w = w + 1;
    e.ea = s;
    e.wb_en = (m == 2'b10);
    e.wb = (m == 2'b10) ? w : '0;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [1:0] m, input logic [1:0] sz, input logic x, input logic sp,
                       input logic [AW-1:0] b, input logic [AW-1:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; mode = m; size = sz; ext = x; is_sp = sp; base = b; disp = d;
    q.push_back(model(m, sz, x, sp, b, d, tag));
    @(negedge clk);
    req_valid = 1'b0;
    disp = ~disp;
    base = ~base;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (mon_on && rsp_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R1 response without request", 32'(rsp_valid), 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(ea == e.ea, {e.tag, " ea"}, 32'(ea), 32'(e.ea));
        chk(wb_en == e.wb_en, {"R6 ", e.tag, " wb_en"}, 32'(wb_en), 32'(e.wb_en));
        if (e.wb_en) chk(wb_value == e.wb, {e.tag, " wb_value"}, 32'(wb_value), 32'(e.wb));
      end
    end
  end

  initial begin
    #200000;
    chk(1'b0, "R1 watchdog expired", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk(rsp_valid == 0 && wb_en == 0, "R9 reset flags", {wb_en, rsp_valid}, 32'd0);
    chk(ea == 0 && wb_value == 0, "R9 reset data", 32'(ea) | 32'(wb_value), 32'd0);
    mon_on = 1'b1;

    drive(2'b00, 2'b01, 1'b0, 1'b0, 20'h01234, 20'h00777, "R2 reg-indirect disp ignored");
    drive(2'b00, 2'b01, 1'b1, 1'b0, 20'h4ABCD, 20'hFFFFF, "R2 reg-indirect ext");
    drive(2'b01, 2'b01, 1'b0, 1'b0, 20'h00100, 20'h00010, "R3 indexed positive");
    drive(2'b01, 2'b01, 1'b0, 1'b0, 20'h00100, 20'h08000, "R3 legacy sign bit15");
    drive(2'b01, 2'b01, 1'b1, 1'b0, 20'h20000, 20'hFFFFE, "R3 ext negative");
    drive(2'b01, 2'b01, 1'b1, 1'b0, 20'h0FFFF, 20'h00002, "R3 ext crosses 64K");
    drive(2'b01, 2'b01, 1'b1, 1'b0, 20'h20000, 20'h08000, "R3 ext bit15 positive");
    drive(2'b01, 2'b01, 1'b0, 1'b0, 20'h0FFFF, 20'h00002, "R4 legacy wrap low base");
    drive(2'b01, 2'b01, 1'b0, 1'b0, 20'h10000, 20'h0FFFE, "R4 legacy high base no wrap");
    drive(2'b11, 2'b01, 1'b0, 1'b0, 20'h7FFFF, 20'hF1234, "R5 absolute legacy");
    drive(2'b11, 2'b01, 1'b1, 1'b0, 20'h7FFFF, 20'hF1234, "R5 absolute ext");
    drive(2'b10, 2'b00, 1'b0, 1'b0, 20'h01000, 20'h00055, "R7 byte increment odd kept R8");
    drive(2'b10, 2'b00, 1'b0, 1'b1, 20'h01000, 20'h00055, "R8 sp byte rounded even");
    drive(2'b10, 2'b01, 1'b1, 1'b1, 20'h02000, 20'h0, "R7 word increment sp");
    drive(2'b10, 2'b10, 1'b1, 1'b0, 20'h03001, 20'h0, "R7 wide increment");
    drive(2'b10, 2'b11, 1'b1, 1'b1, 20'h03001, 20'h0, "R8 wide sp odd base");
    drive(2'b10, 2'b01, 1'b1, 1'b0, 20'hFFFFF, 20'h0, "R7 write-back wraps 20 bits");
    drive(2'b10, 2'b00, 1'b1, 1'b1, 20'hFFFFF, 20'h0, "R8 sp wrap to zero");
    idle(3);
    // R1: back-to-back requests
    @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      logic [1:0] m, sz; logic x, sp; logic [AW-1:0] b, d;
      m = 2'($urandom); sz = 2'($urandom); x = 1'($urandom); sp = 1'($urandom);
      b = AW'($urandom); d = AW'($urandom);
      if (i % 3 == 0) b = b & 20'h0FFFF;
      req_valid = 1'b1; mode = m; size = sz; ext = x; is_sp = sp; base = b; disp = d;
      q.push_back(model(m, sz, x, sp, b, d, "R1 back-to-back R3 R4 R7"));
      @(negedge clk);
    end
    req_valid = 1'b0;
    idle(3);
    chk(rsp_valid == 1'b0, "R1 valid drops when idle", 32'(rsp_valid), 32'd0);
    chk(q.size() == 0, "R1 all responses seen", 32'(q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule